// File: doc/BRIEF.md
# Fuse Protection and Shadow Access Controller

This block stands in front of a one-time-programmable configuration store. The store itself is a register file of `NBLK` blocks of `BLK_W` bits. Block 0 holds configuration fields. Blocks 1 and up are coded data blocks, and blocks 4 to 9 are the six key slots. Program requests name a block and give a bit mask. An accepted request ORs the mask into the stored block, because a fuse bit can only go from 0 to 1. A request is refused when a write-disable bit covers the bits it targets, when its coded block already holds data, or when the block number is out of range.

All consumers see a shadow copy of the store rather than the store itself. The shadow is refreshed only by an explicit reload pulse. As a result, newly programmed protection bits, purposes and enables do nothing until the next reload. Software reads return one 32-bit word of a block. A read-disable bit can hide blocks 4 to 10 from software. Hardware consumers ask for a key slot together with their own purpose code. They receive the full key only when that code matches the slot's programmed purpose, even when the slot is hidden from software. Two 3-bit enable fields are decoded as active when an odd number of their bits is set.

Top module: `fuse_shadow_ctrl`

## Requirements
- R1: After reset every output is 0. The store and the shadow are all zeros, so nothing is protected or enabled.
- R2: An accepted request sets every stored bit whose mask bit is 1 and clears no bit. After a reload the new bits are visible to software reads.
- R3: The shadow changes only on the clock edge that samples `reload`. That edge captures the store as it was before any program request accepted on the same edge. Until then, reads, key delivery, decoded enables and write protection all use the previous shadow.
- R4: The shadowed write-disable word is block 0 bits [31:0]. In block 0, bit 0 protects the read-disable field, bit 1 the debug-disable field, bit 2 the boot-encryption field, and bit 3+k key purpose k. Bit 9 protects every block 0 bit at 45 or above that is not a purpose field. A block 0 request whose mask touches a protected field is rejected. For blocks b ≥ 1, bit 9+b rejects every request to block b. The write-disable word itself is never protected.
- R5: A request to a coded block (b ≥ 1) is rejected when that block in the store already has any bit set. No reload is needed for this check.
- R6: A rejected request, including one naming a block ≥ `NBLK`, raises `prog_err` for exactly the cycle after the request and leaves the store unchanged. An accepted request never raises it.
- R7: A software read returns `sw_rd_ack` one cycle later. `sw_rd_data` is then bits [32w+31:32w] of the shadowed block, where w is the word index.
- R8: Block 0 bits [38:32] are read-disable bits. Bit 32+(b-4) hides block b (4 ≤ b ≤ 10): the read returns data 0 with `sw_rd_denied` high. Blocks 0 to 3 are always readable.
- R9: A hardware key read returns `hw_key_valid` one cycle later. `hw_key` then carries shadowed block 4+s when slot s < 6, the requested code equals purpose s (block 0 bits [48+4s+3:48+4s]), and the code lies in 2 to 11. Read-disable bits do not affect this path. In every other case `hw_key` is all zeros.
- R10: `dbg_soft_off` is high when an odd number of shadowed block 0 bits [41:39] are set. `boot_crypt_on` is high when an odd number of bits [44:42] are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| prog_valid | input | 1 | Program request strobe |
| prog_blk | input | 4 | Target block index |
| prog_mask | input | 256 | Bits to set in the block |
| prog_err | output | 1 | One-cycle pulse for a rejected request |
| reload | input | 1 | Copy the store into the shadow |
| sw_rd_valid | input | 1 | Software read strobe |
| sw_rd_blk | input | 4 | Software read block |
| sw_rd_word | input | 3 | Software read word index |
| sw_rd_ack | output | 1 | Software read result valid |
| sw_rd_data | output | 32 | Software read word |
| sw_rd_denied | output | 1 | Read hidden by read-disable |
| hw_rd_valid | input | 1 | Hardware key request strobe |
| hw_rd_slot | input | 3 | Key slot 0 to 5 |
| hw_rd_purpose | input | 4 | Purpose code of the consumer |
| hw_key_valid | output | 1 | Key result valid |
| hw_key | output | 256 | Delivered key, or zeros |
| dbg_soft_off | output | 1 | Debug soft-disable (odd count) |
| boot_crypt_on | output | 1 | Boot encryption active (odd count) |

## Verification
A corrupted store bit shows up only after the next reload, as a wrong word on a software read or a wrong or missing key on a hardware read. It can also show up earlier as a spurious or missing `prog_err` on a coded block, because the already-programmed test uses the live store. A corrupted shadow appears at once in the decoded enables. It also appears one cycle after the next read, or as a protection decision that is wrong on the very next program request. The bench keeps its own model of the store and the shadow and predicts each read and each error pulse.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
   // block 0 field layout
   localparam int WD_LSB   = 0;
   localparam int WD_W     = 32;
   localparam int RD_LSB   = 32;
   localparam int RD_W     = 7;
   localparam int DBG_LSB  = 39;
   localparam int DBG_W    = 3;
   localparam int CRY_LSB  = 42;
   localparam int CRY_W    = 3;
   localparam int PURP_LSB = 48;
   localparam int PURP_W   = 4;
   // write-disable group bit numbers
   localparam int GRP_RD        = 0;
   localparam int GRP_DBG       = 1;
   localparam int GRP_CRY       = 2;
   localparam int GRP_PURP0     = 3;
   localparam int GRP_BLK_BASE  = 9;   // block b uses bit 9+b, b=0 means other block-0 bits
   // purpose codes usable by hardware consumers
   localparam int PURP_HW_MIN = 2;
   localparam int PURP_HW_MAX = 11;

   typedef logic [PURP_W-1:0] purpose_t;
endpackage

// File: rtl/fuse_store.sv
module fuse_store #(
   parameter int NBLK  = 11,
   parameter int BLK_W = 256,
   localparam int BI_W = $clog2(NBLK)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [BI_W-1:0]             wr_blk,
   input  logic [BLK_W-1:0]            wr_mask,
   input  logic                        reload,
   output logic [NBLK-1:0][BLK_W-1:0]  arr_o,
   output logic [NBLK-1:0][BLK_W-1:0]  shd_o
);
   logic [NBLK-1:0][BLK_W-1:0] arr_q;
   logic [NBLK-1:0][BLK_W-1:0] shd_q;

   for (genvar b = 0; b < NBLK; b++) begin : g_blk
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            arr_q[b] <= '0;
            shd_q[b] <= '0;
         end else begin
            if (wr_en && (wr_blk == BI_W'(b)))
               arr_q[b] <= arr_q[b] | wr_mask;
            if (reload)
               shd_q[b] <= arr_q[b];
         end
      end

      // fuse bits never return to zero
      assert_no_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
         ((arr_q[b] & $past(arr_q[b])) == $past(arr_q[b])));
   end

   // shadow only moves on a reload edge
   assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !reload |=> $stable(shd_q));

   assign arr_o = arr_q;
   assign shd_o = shd_q;
endmodule

// File: rtl/fuse_prog_guard.sv
module fuse_prog_guard
   import fuse_pkg::*;
#(
   parameter int NBLK  = 11,
   parameter int BLK_W = 256,
   parameter int NKEY  = 6,
   localparam int BI_W = $clog2(NBLK),
   localparam int WDU  = GRP_BLK_BASE + NBLK
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic [BI_W-1:0]             req_blk,
   input  logic [BLK_W-1:0]            req_mask,
   input  logic [NBLK-1:0][BLK_W-1:0]  arr_i,
   input  logic [WDU-1:0]              wd_i,
   output logic                        wr_en,
   output logic                        err_o
);
   if (WDU > WD_W) begin : g_bad_nblk
      $error("fuse_prog_guard: too many blocks for the write-disable word");
   end
   if (GRP_PURP0 + NKEY > GRP_BLK_BASE) begin : g_bad_nkey
      $error("fuse_prog_guard: purpose groups overlap block groups");
   end

   logic [BLK_W-1:0] known;
   logic [BLK_W-1:0] prot;
   logic             in_range, used, blk_lock, reject;

   always_comb begin
      known = '0;
      known[WD_LSB +: WD_W]              = '1;
      known[RD_LSB +: RD_W]              = '1;
      known[DBG_LSB +: DBG_W]            = '1;
      known[CRY_LSB +: CRY_W]            = '1;
      known[PURP_LSB +: NKEY*PURP_W]     = '1;
      known[RD_LSB-1:0]                  = '1;
      for (int i = CRY_LSB + CRY_W; i < PURP_LSB; i++) known[i] = 1'b0;

      prot = '0;
      if (wd_i[GRP_RD])  prot[RD_LSB +: RD_W]   = '1;
      if (wd_i[GRP_DBG]) prot[DBG_LSB +: DBG_W] = '1;
      if (wd_i[GRP_CRY]) prot[CRY_LSB +: CRY_W] = '1;
      for (int k = 0; k < NKEY; k++)
         if (wd_i[GRP_PURP0+k]) prot[PURP_LSB + k*PURP_W +: PURP_W] = '1;
      if (wd_i[GRP_BLK_BASE]) prot = prot | ~known;

      in_range = 1'b0;
      used     = 1'b0;
      blk_lock = 1'b0;
      for (int b = 0; b < NBLK; b++) begin
         if (req_blk == BI_W'(b)) begin
            in_range = 1'b1;
            used     = |arr_i[b];
            blk_lock = wd_i[GRP_BLK_BASE+b];
         end
      end

      if (!in_range)
         reject = 1'b1;
      else if (req_blk == '0)
         reject = |(req_mask & prot);
      else
         reject = blk_lock | used;
   end

   assign wr_en = req_valid & ~reject;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_o <= 1'b0;
      else        err_o <= req_valid & reject;
   end

   // an error pulse always follows a request
   assert_err_follows_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(req_valid));
endmodule

// File: rtl/fuse_read_port.sv
module fuse_read_port
   import fuse_pkg::*;
#(
   parameter int NBLK      = 11,
   parameter int BLK_W     = 256,
   parameter int WORD_W    = 32,
   parameter int NKEY      = 6,
   parameter int KEY_FIRST = 4,
   localparam int BI_W     = $clog2(NBLK),
   localparam int WORDS    = BLK_W / WORD_W,
   localparam int WSEL_W   = $clog2(WORDS),
   localparam int SLOT_W   = $clog2(NKEY)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NBLK-1:0][BLK_W-1:0]  shd_i,
   input  logic                        sw_valid,
   input  logic [BI_W-1:0]             sw_blk,
   input  logic [WSEL_W-1:0]           sw_word,
   output logic                        sw_ack,
   output logic [WORD_W-1:0]           sw_data,
   output logic                        sw_denied,
   input  logic                        hw_valid,
   input  logic [SLOT_W-1:0]           hw_slot,
   input  purpose_t                    hw_code,
   output logic                        hw_vld,
   output logic [BLK_W-1:0]            hw_key,
   output logic                        dbg_off,
   output logic                        cry_on
);
   if (KEY_FIRST + RD_W > NBLK) begin : g_bad_rd
      $error("fuse_read_port: read-disable range exceeds block count");
   end
   if (KEY_FIRST + NKEY > NBLK) begin : g_bad_key
      $error("fuse_read_port: key slots exceed block count");
   end
   if (BLK_W % WORD_W != 0) begin : g_bad_word
      $error("fuse_read_port: block width must be a multiple of word width");
   end

   logic [BLK_W-1:0]  sel_blk, key_sel;
   logic [WORD_W-1:0] word_sel;
   logic              locked, slot_ok, hw_match;
   purpose_t          purp;

   always_comb begin
      sel_blk = '0;
      for (int b = 0; b < NBLK; b++)
         if (sw_blk == BI_W'(b)) sel_blk = shd_i[b];
      locked = 1'b0;
      for (int r = 0; r < RD_W; r++)
         if (sw_blk == BI_W'(KEY_FIRST + r)) locked = shd_i[0][RD_LSB + r];
      word_sel = '0;
      for (int w = 0; w < WORDS; w++)
         if (sw_word == WSEL_W'(w)) word_sel = sel_blk[w*WORD_W +: WORD_W];
   end

   always_comb begin
      slot_ok = 1'b0;
      purp    = '0;
      key_sel = '0;
      for (int s = 0; s < NKEY; s++) begin
         if (hw_slot == SLOT_W'(s)) begin
            slot_ok = 1'b1;
            purp    = shd_i[0][PURP_LSB + s*PURP_W +: PURP_W];
            key_sel = shd_i[KEY_FIRST + s];
         end
      end
      hw_match = slot_ok && (purp == hw_code) &&
                 (hw_code >= PURP_W'(PURP_HW_MIN)) && (hw_code <= PURP_W'(PURP_HW_MAX));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_ack    <= 1'b0;
         sw_denied <= 1'b0;
         sw_data   <= '0;
         hw_vld    <= 1'b0;
         hw_key    <= '0;
      end else begin
         sw_ack    <= sw_valid;
         sw_denied <= sw_valid & locked;
         sw_data   <= (sw_valid && !locked) ? word_sel : '0;
         hw_vld    <= hw_valid;
         hw_key    <= (hw_valid && hw_match) ? key_sel : '0;
      end
   end

   assign dbg_off = ^shd_i[0][DBG_LSB +: DBG_W];
   assign cry_on  = ^shd_i[0][CRY_LSB +: CRY_W];

   assert_ack_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sw_ack |-> $past(sw_valid));
   assert_denied_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sw_denied |-> (sw_ack && sw_data == '0));
   assert_key_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_vld |-> (hw_key == '0));
   assert_key_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hw_vld |-> $past(hw_valid));
endmodule

// File: rtl/fuse_shadow_ctrl.sv
module fuse_shadow_ctrl
   import fuse_pkg::*;
#(
   parameter int NBLK      = 11,
   parameter int BLK_W     = 256,
   parameter int WORD_W    = 32,
   parameter int NKEY      = 6,
   parameter int KEY_FIRST = 4,
   localparam int BI_W     = $clog2(NBLK),
   localparam int WSEL_W   = $clog2(BLK_W / WORD_W),
   localparam int SLOT_W   = $clog2(NKEY),
   localparam int WDU      = GRP_BLK_BASE + NBLK
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               prog_valid,
   input  logic [BI_W-1:0]    prog_blk,
   input  logic [BLK_W-1:0]   prog_mask,
   output logic               prog_err,
   input  logic               reload,
   input  logic               sw_rd_valid,
   input  logic [BI_W-1:0]    sw_rd_blk,
   input  logic [WSEL_W-1:0]  sw_rd_word,
   output logic               sw_rd_ack,
   output logic [WORD_W-1:0]  sw_rd_data,
   output logic               sw_rd_denied,
   input  logic               hw_rd_valid,
   input  logic [SLOT_W-1:0]  hw_rd_slot,
   input  logic [PURP_W-1:0]  hw_rd_purpose,
   output logic               hw_key_valid,
   output logic [BLK_W-1:0]   hw_key,
   output logic               dbg_soft_off,
   output logic               boot_crypt_on
);
   if (BLK_W < PURP_LSB + NKEY*PURP_W) begin : g_bad_width
      $error("fuse_shadow_ctrl: block too narrow for configuration layout");
   end

   logic [NBLK-1:0][BLK_W-1:0] arr_w, shd_w;
   logic                       wr_en;

   fuse_prog_guard #(.NBLK(NBLK), .BLK_W(BLK_W), .NKEY(NKEY)) guard_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (prog_valid),
      .req_blk   (prog_blk),
      .req_mask  (prog_mask),
      .arr_i     (arr_w),
      .wd_i      (shd_w[0][WDU-1:0]),
      .wr_en     (wr_en),
      .err_o     (prog_err)
   );

   fuse_store #(.NBLK(NBLK), .BLK_W(BLK_W)) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_blk  (prog_blk),
      .wr_mask (prog_mask),
      .reload  (reload),
      .arr_o   (arr_w),
      .shd_o   (shd_w)
   );

   fuse_read_port #(.NBLK(NBLK), .BLK_W(BLK_W), .WORD_W(WORD_W),
                    .NKEY(NKEY), .KEY_FIRST(KEY_FIRST)) rd_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .shd_i     (shd_w),
      .sw_valid  (sw_rd_valid),
      .sw_blk    (sw_rd_blk),
      .sw_word   (sw_rd_word),
      .sw_ack    (sw_rd_ack),
      .sw_data   (sw_rd_data),
      .sw_denied (sw_rd_denied),
      .hw_valid  (hw_rd_valid),
      .hw_slot   (hw_rd_slot),
      .hw_code   (hw_rd_purpose),
      .hw_vld    (hw_key_valid),
      .hw_key    (hw_key),
      .dbg_off   (dbg_soft_off),
      .cry_on    (boot_crypt_on)
   );

   // a rejected request leaves the store untouched
   assert_reject_keeps_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
      prog_err |-> (arr_w == $past(arr_w)));
endmodule

// File: tb/fuse_shadow_ctrl_tb_top.sv
module fuse_shadow_ctrl_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         prog_valid = 1'b0;
   logic [3:0]   prog_blk = '0;
   logic [255:0] prog_mask = '0;
   logic         prog_err;
   logic         reload = 1'b0;
   logic         sw_rd_valid = 1'b0;
   logic [3:0]   sw_rd_blk = '0;
   logic [2:0]   sw_rd_word = '0;
   logic         sw_rd_ack;
   logic [31:0]  sw_rd_data;
   logic         sw_rd_denied;
   logic         hw_rd_valid = 1'b0;
   logic [2:0]   hw_rd_slot = '0;
   logic [3:0]   hw_rd_purpose = '0;
   logic         hw_key_valid;
   logic [255:0] hw_key;
   logic         dbg_soft_off, boot_crypt_on;

   always #5 clk = ~clk;

   fuse_shadow_ctrl dut_i (.*);

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [255:0] bm_arr [11];
   logic [255:0] bm_sh  [11];

   logic [32:0]  sw_q [$];
   string        sw_tag [$];
   logic [255:0] hw_q [$];
   string        hw_tag [$];

   task automatic chk(string rq, logic [255:0] act, logic [255:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic bit exp_reject(int blk, logic [255:0] m);
      logic [31:0]  wd;
      logic [255:0] p;
      if (blk >= 11) return 1'b1;
      wd = bm_sh[0][31:0];
      if (blk != 0) return wd[9+blk] | (|bm_arr[blk]);
      p = '0;
      if (wd[0]) p[38:32] = '1;
      if (wd[1]) p[41:39] = '1;
      if (wd[2]) p[44:42] = '1;
      for (int k = 0; k < 6; k++) if (wd[3+k]) p[48+4*k +: 4] = '1;
      if (wd[9]) begin
         p[47:45] = '1;
         p[255:72] = '1;
      end
      return |(m & p);
   endfunction

   task automatic prog(string rq, int blk, logic [255:0] m, bit with_reload);
      bit rj;
      @(negedge clk);
      rj = exp_reject(blk, m);
      prog_valid = 1'b1;
      prog_blk   = 4'(blk);
      prog_mask  = m;
      reload     = with_reload;
      if (with_reload) for (int b = 0; b < 11; b++) bm_sh[b] = bm_arr[b];
      if (!rj) bm_arr[blk] = bm_arr[blk] | m;
      @(negedge clk);
      prog_valid = 1'b0;
      reload     = 1'b0;
      chk({rq, " prog_err"}, 256'(prog_err), 256'(rj));
      @(negedge clk);
      chk({rq, " prog_err one cycle"}, 256'(prog_err), 256'(0));
   endtask

   task automatic do_reload();
      @(negedge clk);
      reload = 1'b1;
      for (int b = 0; b < 11; b++) bm_sh[b] = bm_arr[b];
      @(negedge clk);
      reload = 1'b0;
   endtask

   task automatic swrd(string rq, int blk, int w);
      logic lk;
      @(negedge clk);
      lk = (blk >= 4 && blk <= 10) ? bm_sh[0][32+blk-4] : 1'b0;
      sw_q.push_back(lk ? {1'b1, 32'h0} : {1'b0, bm_sh[blk][32*w +: 32]});
      sw_tag.push_back(rq);
      sw_rd_valid = 1'b1;
      sw_rd_blk   = 4'(blk);
      sw_rd_word  = 3'(w);
      @(negedge clk);
      sw_rd_valid = 1'b0;
   endtask

   task automatic hwrd(string rq, int s, int code);
      logic [255:0] e;
      e = '0;
      if (s < 6 && code >= 2 && code <= 11 && bm_sh[0][48+4*s +: 4] == 4'(code))
         e = bm_sh[4+s];
      @(negedge clk);
      hw_q.push_back(e);
      hw_tag.push_back(rq);
      hw_rd_valid   = 1'b1;
      hw_rd_slot    = 3'(s);
      hw_rd_purpose = 4'(code);
      @(negedge clk);
      hw_rd_valid = 1'b0;
   endtask

   task automatic chk_dec(string rq);
      chk({rq, " dbg_soft_off"}, 256'(dbg_soft_off), 256'(^bm_sh[0][41:39]));
      chk({rq, " boot_crypt_on"}, 256'(boot_crypt_on), 256'(^bm_sh[0][44:42]));
   endtask

   // monitors
   always @(negedge clk) begin
      if (rst_n && sw_rd_ack) begin
         if (sw_q.size() == 0) chk("R7 unexpected ack", 256'(1), 256'(0));
         else begin
            logic [32:0] e;
            string t;
            e = sw_q.pop_front();
            t = sw_tag.pop_front();
            chk({t, " data"}, 256'(sw_rd_data), 256'(e[31:0]));
            chk({t, " denied"}, 256'(sw_rd_denied), 256'(e[32]));
         end
      end
      if (rst_n && hw_key_valid) begin
         if (hw_q.size() == 0) chk("R9 unexpected key", 256'(1), 256'(0));
         else begin
            string t;
            t = hw_tag.pop_front();
            chk({t, " key"}, hw_key, hw_q.pop_front());
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [255:0] pa, k5, m;
      for (int b = 0; b < 11; b++) begin
         bm_arr[b] = '0;
         bm_sh[b]  = '0;
      end
      pa = {8{32'h3C5A_9617}} ^ {32'h0, 32'h1, 32'h2, 32'h3, 32'h4, 32'h5, 32'h6, 32'h7};
      k5 = {8{32'hD00D_F00D}} ^ {8{32'h0101_0101}} << 3;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1 prog_err", 256'(prog_err), 256'(0));
      chk("R1 sw_rd_ack", 256'(sw_rd_ack), 256'(0));
      chk("R1 hw_key_valid", 256'(hw_key_valid), 256'(0));
      chk("R1 hw_key", hw_key, 256'(0));
      chk("R1 dbg_soft_off", 256'(dbg_soft_off), 256'(0));
      chk("R1 boot_crypt_on", 256'(boot_crypt_on), 256'(0));
      swrd("R1 read block0", 0, 0);

      // R2 / R3 / R7: program, invisible before reload, visible after
      prog("R2 first program block3", 3, pa, 1'b0);
      swrd("R3 block3 before reload", 3, 0);
      do_reload();
      swrd("R2 block3 word0", 3, 0);
      swrd("R7 block3 word7", 3, 7);
      swrd("R7 block3 word4", 3, 4);

      // R5: coded block only once; R6 store unchanged
      prog("R5 second program block3", 3, ~pa, 1'b0);
      do_reload();
      swrd("R6 block3 unchanged", 3, 5);

      // R10 odd count decoding, R3 delayed effect
      m = '0; m[39] = 1'b1; m[42] = 1'b1; m[43] = 1'b1; m[44] = 1'b1;
      prog("R10 set enable bits", 0, m, 1'b0);
      chk_dec("R3 enables before reload");
      do_reload();
      chk_dec("R10 one and three bits");
      m = '0; m[40] = 1'b1;
      prog("R2 OR second debug bit", 0, m, 1'b0);
      do_reload();
      chk_dec("R10 two bits even");

      // R8 / R9: key slot1 with purpose 6, hidden from software
      prog("R2 program key block5", 5, k5, 1'b0);
      m = '0; m[53] = 1'b1; m[54] = 1'b1; m[33] = 1'b1;
      prog("R2 purpose and read-disable", 0, m, 1'b0);
      swrd("R3 block5 readable before reload", 5, 1);
      do_reload();
      swrd("R8 block5 denied", 5, 1);
      swrd("R8 block3 readable", 3, 2);
      swrd("R8 block0 word1", 0, 1);
      hwrd("R9 slot1 matching code", 1, 6);
      hwrd("R9 slot1 wrong code", 1, 7);
      hwrd("R9 slot0 code 0 never matches", 0, 0);
      hwrd("R9 slot 6 out of range", 6, 6);

      // R4 write protection, taking effect only after reload
      m = '0; m[5] = 1'b1; m[17] = 1'b1;
      prog("R4 set write-disable bits", 0, m, 1'b0);
      m = '0; m[56] = 1'b1;
      prog("R4 purpose2 before reload accepted", 0, m, 1'b0);
      do_reload();
      m = '0; m[57] = 1'b1;
      prog("R4 purpose2 protected", 0, m, 1'b0);
      prog("R4 block8 protected", 8, pa, 1'b0);
      m = '0; m[80] = 1'b1; m[6] = 1'b1;
      prog("R4 misc bits unprotected", 0, m, 1'b0);
      prog("R4 block9 unprotected", 9, k5, 1'b0);
      do_reload();
      swrd("R4 block0 word1", 0, 1);
      swrd("R4 block0 word2", 0, 2);
      swrd("R4 block8 empty", 8, 0);
      swrd("R4 block9 data", 9, 6);
      m = '0; m[81] = 1'b1; m[9] = 1'b1;
      prog("R4 set misc protect", 0, m, 1'b0);
      do_reload();
      m = '0; m[100] = 1'b1;
      prog("R4 misc protected", 0, m, 1'b0);

      // R6 out of range
      prog("R6 block 11 rejected", 11, pa, 1'b0);
      prog("R6 block 15 rejected", 15, pa, 1'b0);

      // R3 reload captures pre-program state
      prog("R3 program block1 with reload", 1, pa, 1'b1);
      swrd("R3 block1 old value", 1, 3);
      do_reload();
      swrd("R3 block1 new value", 1, 3);

      repeat (4) @(negedge clk);
      chk("R7 sw queue drained", 256'(sw_q.size()), 256'(0));
      chk("R9 hw queue drained", 256'(hw_q.size()), 256'(0));
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule